// File: doc/BRIEF.md
# Pin Task and Event Channel

This block is a single channel that can claim one general-purpose pin out of a bank of pins. The pin is chosen by a pin number and a port number in a configuration word. In task mode the channel drives the pin as an output. Three one-cycle strobes act on it: one forces it high, one forces it low, and one applies a configurable action. In event mode the channel forces the pin to be an input. It synchronises the pin's level and emits a one-cycle pulse when the edge named in the configuration appears.

For every pin the channel does not own, and for all pins when the channel is disabled, the ordinary GPIO drive and direction values pass straight through to the pad side. An ownership vector shows which pin, if any, the channel currently holds. The held drive value is register state. A strobe is applied on the clock edge where it is sampled, so the effect appears on the pad one cycle later. The configuration word is used as it stands on each cycle and is not registered.

Top module: `pin_task_event_chan`

## Requirements
- R1: While reset is asserted, evt_pulse is 0 and, with a zero configuration word, pad_out and pad_dir equal gpio_out and gpio_dir and pin_owned is all zero.
- R2: The mode field is bits 1:0. Value 0 and value 2 both mean disabled. In that state pin_owned is zero and every pad_out and pad_dir bit equals the matching gpio_out and gpio_dir bit.
- R3: Value 3 in the mode field is task mode. The selected pin has index port*32+pin, where the pin number is bits 12:8 and the port is bit 13. That pin gets pad_dir=1 and pin_owned=1, and its pad_out ignores gpio_out. All other pins pass through.
- R4: On the first task-mode edge that follows a non-task cycle, the held drive value is loaded from bit 20 of the configuration. Any strobes on that same edge are ignored.
- R5: In task mode, a lone clear strobe drives the pin low on the next cycle, and a lone set strobe drives it high.
- R6: The polarity field is bits 17:16. In task mode the configurable strobe acts by polarity: 0 leaves the pin unchanged, 1 drives it high, 2 drives it low, and 3 inverts it.
- R7: When strobes coincide, the configurable strobe wins over clear, and clear wins over set. This holds even when polarity is 0, in which case the pin stays unchanged.
- R8: Value 1 in the mode field is event mode. The selected pin gets pad_dir=0 and pin_owned=1, and its pad_out follows gpio_out.
- R9: In event mode, the pin goes through two synchronising flops and evt_pulse rises one cycle later. A level change seen before edge k therefore shows evt_pulse high for exactly the cycle after edge k+2. Polarity 1 reacts to rising edges, 2 to falling edges, 3 to both, and 0 never pulses.
- R10: Outside task mode, the strobes have no effect on pad_out, pad_dir or pin_owned.
- R11: In task mode with no strobe, the held drive value stays the same from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_word | input | 32 | Configuration: mode, pin, port, polarity, initial value |
| tsk_set | input | 1 | One-cycle strobe that drives the owned pin high |
| tsk_clr | input | 1 | One-cycle strobe that drives the owned pin low |
| tsk_out | input | 1 | One-cycle strobe with the action chosen by polarity |
| pin_in | input | 64 | Sampled pad input levels |
| gpio_out | input | 64 | Ordinary GPIO drive values |
| gpio_dir | input | 64 | Ordinary GPIO directions (1 = output) |
| pad_out | output | 64 | Drive value presented to each pad |
| pad_dir | output | 64 | Direction presented to each pad |
| pin_owned | output | 64 | One-hot flag for the pin held by the channel |
| evt_pulse | output | 1 | One-cycle edge event |

## Verification
Several pairs of functions can fall in the same clock cycle. The configurable strobe can arrive together with the clear and set strobes, and any strobe can arrive on the very edge where task mode is entered and the initial value is loaded. Directed cycles cover both cases, including the one where polarity 0 must hold the pin against a simultaneous set or clear. A random phase then raises all three strobes independently while the mode and polarity change around them. A bench model follows the priority order and the entry-load rule and sets the expected pad value. That value is compared with the owned pin's drive one cycle after each edge.

// File: rtl/pte_pkg.sv
package pte_pkg;

  // Field positions inside the configuration word
  localparam int MODE_LSB  = 0;
  localparam int PSEL_LSB  = 8;
  localparam int PORT_LSB  = 13;
  localparam int POL_LSB   = 16;
  localparam int INIT_BIT  = 20;

  typedef enum logic [1:0] {
    MD_OFF  = 2'd0,
    MD_EVT  = 2'd1,
    MD_TASK = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_RISE = 2'd1,
    POL_FALL = 2'd2,
    POL_TOG  = 2'd3
  } pol_e;

  typedef struct packed {
    mode_e mode;
    pol_e  pol;
    logic  init;
  } chan_cfg_t;

endpackage

// File: rtl/pte_cfg_decode.sv
module pte_cfg_decode
  import pte_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int PSEL_W = 5,
  parameter int PORT_W = 1,
  localparam int IDX_W = PSEL_W + PORT_W
) (
  input  logic [CFG_W-1:0] cfg_word,
  output chan_cfg_t        cfg,
  output logic [IDX_W-1:0] pin_idx
);

  always_comb begin
    cfg = '0;
    case (cfg_word[MODE_LSB +: 2])
      2'd1:    cfg.mode = MD_EVT;
      2'd3:    cfg.mode = MD_TASK;
      default: cfg.mode = MD_OFF;
    endcase
    cfg.pol  = pol_e'(cfg_word[POL_LSB +: 2]);
    cfg.init = cfg_word[INIT_BIT];
  end

  assign pin_idx = {cfg_word[PORT_LSB +: PORT_W], cfg_word[PSEL_LSB +: PSEL_W]};

endmodule

// File: rtl/pte_task_unit.sv
module pte_task_unit
  import pte_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chan_cfg_t cfg,
  input  logic      tsk_set,
  input  logic      tsk_clr,
  input  logic      tsk_out,
  output logic      drive_q
);

  logic is_task;
  logic was_task_q;
  logic entry;
  logic drive_en;
  logic drive_d;

  assign is_task = (cfg.mode == MD_TASK);
  assign entry   = is_task & ~was_task_q;

  // Next-state: entry load, then configurable strobe, then clear, then set
  always_comb begin
    drive_en = 1'b0;
    drive_d  = drive_q;
    if (entry) begin
      drive_en = 1'b1;
      drive_d  = cfg.init;
    end else if (is_task) begin
      if (tsk_out) begin
        drive_en = 1'b1;
        case (cfg.pol)
          POL_RISE: drive_d = 1'b1;
          POL_FALL: drive_d = 1'b0;
          POL_TOG:  drive_d = ~drive_q;
          default:  drive_d = drive_q;
        endcase
      end else if (tsk_clr) begin
        drive_en = 1'b1;
        drive_d  = 1'b0;
      end else if (tsk_set) begin
        drive_en = 1'b1;
        drive_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_task_q <= 1'b0;
      drive_q    <= 1'b0;
    end else begin
      was_task_q <= is_task;
      if (drive_en) drive_q <= drive_d;
    end
  end

endmodule

// File: rtl/pte_event_unit.sv
module pte_event_unit
  import pte_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  chan_cfg_t cfg,
  input  logic      pin_lvl,
  output logic      evt_q
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   hist_q;
  logic                   newest;
  logic                   rise;
  logic                   fall;
  logic                   evt_d;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      assign sync_d = pin_lvl;
    end else begin : g_syncn
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pin_lvl};
    end
  endgenerate

  assign newest = sync_q[SYNC_STAGES-1];
  assign rise   = newest & ~hist_q;
  assign fall   = ~newest & hist_q;

  always_comb begin
    evt_d = 1'b0;
    if (cfg.mode == MD_EVT) begin
      case (cfg.pol)
        POL_RISE: evt_d = rise;
        POL_FALL: evt_d = fall;
        POL_TOG:  evt_d = rise | fall;
        default:  evt_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= newest;
      evt_q  <= evt_d;
    end
  end

endmodule

// File: rtl/pte_pin_mux.sv
module pte_pin_mux
  import pte_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int NPINS = 1 << IDX_W
) (
  input  chan_cfg_t        cfg,
  input  logic [IDX_W-1:0] pin_idx,
  input  logic             drive_q,
  input  logic [NPINS-1:0] gpio_out,
  input  logic [NPINS-1:0] gpio_dir,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_dir,
  output logic [NPINS-1:0] pin_owned
);

  logic as_task;
  logic as_evt;

  assign as_task = (cfg.mode == MD_TASK);
  assign as_evt  = (cfg.mode == MD_EVT);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic hit;
    assign hit          = (pin_idx == IDX_W'(p));
    assign pin_owned[p] = hit & (as_task | as_evt);
    assign pad_dir[p]   = (hit & as_task) ? 1'b1 :
                          (hit & as_evt)  ? 1'b0 : gpio_dir[p];
    assign pad_out[p]   = (hit & as_task) ? drive_q : gpio_out[p];
  end

endmodule

// File: rtl/pin_task_event_chan.sv
module pin_task_event_chan
  import pte_pkg::*;
#(
  parameter int CFG_W       = 32,
  parameter int PSEL_W      = 5,
  parameter int PORT_W      = 1,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = PSEL_W + PORT_W,
  localparam int NPINS      = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             tsk_set,
  input  logic             tsk_clr,
  input  logic             tsk_out,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] gpio_out,
  input  logic [NPINS-1:0] gpio_dir,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_dir,
  output logic [NPINS-1:0] pin_owned,
  output logic             evt_pulse
);

  chan_cfg_t        cfg;
  logic [IDX_W-1:0] pin_idx;
  logic             drive_q;
  logic             pin_lvl;

  pte_cfg_decode #(.CFG_W(CFG_W), .PSEL_W(PSEL_W), .PORT_W(PORT_W)) u_dec (
    .cfg_word (cfg_word),
    .cfg      (cfg),
    .pin_idx  (pin_idx)
  );

  pte_task_unit u_task (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg),
    .tsk_set (tsk_set),
    .tsk_clr (tsk_clr),
    .tsk_out (tsk_out),
    .drive_q (drive_q)
  );

  assign pin_lvl = pin_in[pin_idx];

  pte_event_unit #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg),
    .pin_lvl (pin_lvl),
    .evt_q   (evt_pulse)
  );

  pte_pin_mux #(.IDX_W(IDX_W)) u_mux (
    .cfg       (cfg),
    .pin_idx   (pin_idx),
    .drive_q   (drive_q),
    .gpio_out  (gpio_out),
    .gpio_dir  (gpio_dir),
    .pad_out   (pad_out),
    .pad_dir   (pad_dir),
    .pin_owned (pin_owned)
  );

endmodule

// File: rtl/pte_chan_checker.sv
module pte_chan_checker
  import pte_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int PSEL_W = 5,
  parameter int PORT_W = 1,
  localparam int IDX_W = PSEL_W + PORT_W,
  localparam int NPINS = 1 << IDX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_word,
  input logic             tsk_out,
  input logic [NPINS-1:0] gpio_dir,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_dir,
  input logic [NPINS-1:0] pin_owned,
  input logic             evt_pulse
);

  logic [IDX_W-1:0] c_idx;
  logic             c_task;
  logic             c_evt;

  assign c_idx  = {cfg_word[PORT_LSB +: PORT_W], cfg_word[PSEL_LSB +: PSEL_W]};
  assign c_task = (cfg_word[MODE_LSB +: 2] == 2'd3);
  assign c_evt  = (cfg_word[MODE_LSB +: 2] == 2'd1);

  // R2: disabled leaves every pin to ordinary GPIO
  a_r2_disabled_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_task && !c_evt) |-> (pin_owned == '0 && pad_dir == gpio_dir));

  // R3: owned pin becomes output in task mode
  a_r3_task_owns_output: assert property (@(posedge clk) disable iff (!rst_n)
    c_task |-> (pad_dir[c_idx] && $onehot0(pin_owned) && pin_owned[c_idx]));

  // R8: owned pin becomes input in event mode
  a_r8_event_owns_input: assert property (@(posedge clk) disable iff (!rst_n)
    c_evt |-> (!pad_dir[c_idx] && $onehot0(pin_owned) && pin_owned[c_idx]));

  // R4: entry into task mode loads the initial value
  a_r4_entry_load: assert property (@(posedge clk) disable iff (!rst_n)
    (c_task && $past(!c_task)) |=>
      (!$stable(cfg_word) || pad_out[c_idx] == cfg_word[INIT_BIT]));

  // R7: polarity none on the configurable strobe holds the pin
  a_r7_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (c_task && $past(c_task) && tsk_out && cfg_word[POL_LSB +: 2] == 2'd0) |=>
      (!$stable(cfg_word) || pad_out[c_idx] == $past(pad_out[c_idx])));

  // R9: an event pulse only follows a cycle spent in event mode
  a_r9_evt_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> $past(c_evt));

endmodule

bind pin_task_event_chan pte_chan_checker #(
  .CFG_W(CFG_W), .PSEL_W(PSEL_W), .PORT_W(PORT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_word  (cfg_word),
  .tsk_out   (tsk_out),
  .gpio_dir  (gpio_dir),
  .pad_out   (pad_out),
  .pad_dir   (pad_dir),
  .pin_owned (pin_owned),
  .evt_pulse (evt_pulse)
);

// File: tb/pin_task_event_chan_tb.sv
module pin_task_event_chan_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        tsk_set, tsk_clr, tsk_out;
  logic [63:0] pin_in, gpio_out, gpio_dir;
  logic [63:0] pad_out, pad_dir, pin_owned;
  logic        evt_pulse;

  int n_run;
  int n_fail;
  bit done;

  // bench model state
  logic  m_out, m_was, m_s1, m_s2, m_s3, m_evt;
  string act_tag;

  pin_task_event_chan u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .tsk_set(tsk_set), .tsk_clr(tsk_clr), .tsk_out(tsk_out),
    .pin_in(pin_in), .gpio_out(gpio_out), .gpio_dir(gpio_dir),
    .pad_out(pad_out), .pad_dir(pad_dir), .pin_owned(pin_owned),
    .evt_pulse(evt_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [1:0] f_mode(input logic [31:0] w);
    if (w[1:0] == 2'd1) return 2'd1;
    if (w[1:0] == 2'd3) return 2'd3;
    return 2'd0;
  endfunction

  function automatic int f_idx(input logic [31:0] w);
    return int'({w[13], w[12:8]});
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [1:0] md;
    logic [1:0] pol;
    logic       ev;
    md  = f_mode(cfg_word);
    pol = cfg_word[17:16];
    if (md == 2'd3 && !m_was) begin
      m_out = cfg_word[20];
      act_tag = "R4";
    end else if (md == 2'd3) begin
      if (tsk_out) begin
        if (pol == 2'd1) m_out = 1'b1;
        else if (pol == 2'd2) m_out = 1'b0;
        else if (pol == 2'd3) m_out = ~m_out;
        act_tag = (tsk_clr || tsk_set) ? "R7" : "R6";
      end else if (tsk_clr) begin
        m_out = 1'b0;
        act_tag = tsk_set ? "R7" : "R5";
      end else if (tsk_set) begin
        m_out = 1'b1;
        act_tag = "R5";
      end else begin
        act_tag = "R11";
      end
    end else begin
      act_tag = "R10";
    end
    ev = 1'b0;
    if (md == 2'd1) begin
      if (pol == 2'd1) ev = m_s2 & ~m_s3;
      else if (pol == 2'd2) ev = ~m_s2 & m_s3;
      else if (pol == 2'd3) ev = m_s2 ^ m_s3;
    end
    m_s3  = m_s2;
    m_s2  = m_s1;
    m_s1  = pin_in[f_idx(cfg_word)];
    m_was = (md == 2'd3);
    m_evt = ev;
  endtask

  task automatic check_outputs();
    logic [1:0]  md;
    int          ix;
    logic [63:0] e_out, e_dir, e_own;
    string       mtag, otag;
    md    = f_mode(cfg_word);
    ix    = f_idx(cfg_word);
    e_out = gpio_out;
    e_dir = gpio_dir;
    e_own = '0;
    mtag  = (md == 2'd3) ? "R3" : (md == 2'd1) ? "R8" : "R2";
    if (md == 2'd3) begin
      e_out[ix] = m_out; e_dir[ix] = 1'b1; e_own[ix] = 1'b1;
      otag = act_tag;
    end else begin
      if (md == 2'd1) begin e_dir[ix] = 1'b0; e_own[ix] = 1'b1; end
      otag = (tsk_set || tsk_clr || tsk_out) ? "R10" : mtag;
    end
    chk(pad_out == e_out, otag, pad_out, e_out);
    chk(pad_dir == e_dir, mtag, pad_dir, e_dir);
    chk(pin_owned == e_own, mtag, pin_owned, e_own);
    chk(evt_pulse == m_evt, "R9", {63'd0, evt_pulse}, {63'd0, m_evt});
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic drive(input logic [31:0] w, input logic s, input logic c, input logic o);
    cfg_word = w; tsk_set = s; tsk_clr = c; tsk_out = o;
  endtask

  // cfg word: mode[1:0], pin[12:8], port[13], polarity[17:16], init[20]
  function automatic logic [31:0] mk(input int md, input int idx, input int pol, input int init);
    logic [31:0] w;
    w = '0;
    w[1:0]   = md[1:0];
    w[13:8]  = idx[5:0];
    w[17:16] = pol[1:0];
    w[20]    = init[0];
    return w;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    n_run = 0; n_fail = 0; done = 0;
    m_out = 0; m_was = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_evt = 0;
    act_tag = "R1";
    rst_n = 1'b0;
    drive(32'd0, 0, 0, 0);
    pin_in = '0;
    gpio_out = 64'hA5A5_0F0F_3C3C_9696;
    gpio_dir = 64'h00FF_00FF_F0F0_1234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(evt_pulse == 1'b0, "R1", {63'd0, evt_pulse}, 64'd0);
    chk(pad_out == gpio_out, "R1", pad_out, gpio_out);
    chk(pad_dir == gpio_dir, "R1", pad_dir, gpio_dir);
    chk(pin_owned == '0, "R1", pin_owned, 64'd0);
    rst_n = 1'b1;

    // R4: enter task on pin 37 with init 1, a clear on the entry edge is ignored
    drive(mk(3, 37, 0, 1), 0, 1, 0); tick();
    chk(pad_out[37] == 1'b1, "R4", {63'd0, pad_out[37]}, 64'd1);
    // R7: polarity none with set and clear together leaves the pin alone
    drive(mk(3, 37, 0, 1), 1, 1, 1); tick();
    chk(pad_out[37] == 1'b1, "R7", {63'd0, pad_out[37]}, 64'd1);
    // R7: clear beats set
    drive(mk(3, 37, 0, 1), 1, 1, 0); tick();
    chk(pad_out[37] == 1'b0, "R7", {63'd0, pad_out[37]}, 64'd0);
    // R5: set alone
    drive(mk(3, 37, 0, 1), 1, 0, 0); tick();
    chk(pad_out[37] == 1'b1, "R5", {63'd0, pad_out[37]}, 64'd1);
    // R7: configurable (low) beats set
    drive(mk(3, 37, 2, 1), 1, 0, 1); tick();
    chk(pad_out[37] == 1'b0, "R7", {63'd0, pad_out[37]}, 64'd0);
    // R6: toggle twice
    drive(mk(3, 37, 3, 1), 0, 0, 1); tick();
    chk(pad_out[37] == 1'b1, "R6", {63'd0, pad_out[37]}, 64'd1);
    tick();
    chk(pad_out[37] == 1'b0, "R6", {63'd0, pad_out[37]}, 64'd0);
    // R11: held with no strobe
    drive(mk(3, 37, 3, 1), 0, 0, 0); tick(); tick();
    chk(pad_out[37] == 1'b0, "R11", {63'd0, pad_out[37]}, 64'd0);
    // R10: disabled (mode 2) strobes change nothing
    drive(mk(2, 37, 1, 1), 1, 0, 1); tick();
    chk(pad_out == gpio_out, "R10", pad_out, gpio_out);
    // R9: rising edge on pin 3, pulse after two more edges
    drive(mk(1, 3, 1, 0), 0, 0, 0);
    repeat (4) tick();
    pin_in[3] = 1'b1; tick(); tick(); tick();
    chk(evt_pulse == 1'b1, "R9", {63'd0, evt_pulse}, 64'd1);
    tick();
    chk(evt_pulse == 1'b0, "R9", {63'd0, evt_pulse}, 64'd0);
    pin_in[3] = 1'b0; repeat (4) tick();
    chk(evt_pulse == 1'b0, "R9", {63'd0, evt_pulse}, 64'd0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 19) == 0) cfg_word = $urandom;
      if ($urandom_range(0, 3) == 0) pin_in[f_idx(cfg_word)] = ~pin_in[f_idx(cfg_word)];
      if ($urandom_range(0, 7) == 0) pin_in = {$urandom, $urandom};
      if ($urandom_range(0, 9) == 0) begin
        gpio_out = {$urandom, $urandom};
        gpio_dir = {$urandom, $urandom};
      end
      tsk_set = ($urandom_range(0, 3) == 0);
      tsk_clr = ($urandom_range(0, 3) == 0);
      tsk_out = ($urandom_range(0, 3) == 0);
      tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule